// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a clock-synchronous model of a word-organised serial EEPROM with a select line, a serial clock, a data input and a separate data output. While the select line is high, each rising edge of the serial clock samples one bit of a command frame. A frame is a start bit, a two-bit opcode and an address. The block then reads a 16-bit word out, takes a 16-bit word in, or sets or clears its write-enable latch. The serial clock is sampled by the system clock, so its edges must be at least two system clocks apart.

An accepted write is committed when the select line falls, and a self-timed programming interval then starts. Its length is a cycle count. Whenever the select line is high after that, the data output shows busy (0) or ready (1). This status remains until the start bit of a later command is taken. On the 128-word variant, a guard input stops writes to the lower 64 words. The output has a separate enable, which stands for the tri-state control of a real pin.

Top module: `serial_eeprom_slave`

## Requirements
- R1: The store holds 2**ADDR_W words of 16 bits (ADDR_W = 6 or 7). A READ returns the last word that was committed to that address, and every word reads 0 after reset.
- R2: Zeros before the start bit (1) are skipped. The opcode follows MSB first: 10 = READ, 01 = WRITE, 00 = extended. Then ADDR_W address bits follow MSB first. For an extended command, the top two address bits 11 select enable-writes and 00 select disable-writes. The codes 01 and 10 have no effect.
- R3: Bits are sampled on the rising serial clock edge. After the last address bit of a READ, the output drives a dummy 0. The next 16 rising edges each present one data bit, from bit 15 down to bit 0. The rising edge after that releases the output.
- R4: Reset clears the write-enable latch. A WRITE while the latch is clear changes no word and starts no programming.
- R5: The latch stays set until a disable-writes command or a reset. READ works whatever the latch state is.
- R6: When ADDR_W = 7 and low_wr_allow is 0, writes to addresses 0 to 63 are dropped. Addresses 64 to 127 stay writable. With low_wr_allow at 1, all addresses are writable.
- R7: Programming starts only when the select line falls after a WRITE frame with all 16 data bits. It lasts PROG_CYCLES clocks. A frame cut short by the select line commits nothing.
- R8: With the select line high after a committed write, sdout_en is 1. sdout is 0 while programming runs and 1 once it has finished.
- R9: sdout_en is 0 while the select line is low and during command entry.
- R10: While programming runs, every serial clock edge is ignored, start bits included. Once ready, the status stays on the output until a start bit is clocked in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low reset; clears the latch, status and store |
| sel | input | 1 | Select line, active high |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| sdin | input | 1 | Serial command, address and write data |
| low_wr_allow | input | 1 | 1 permits writes to the lower 64 words (128-word variant) |
| sdout | output | 1 | Serial read data or busy/ready level |
| sdout_en | output | 1 | Output enable of sdout; 0 means floating |

## Verification
The hardest state to reach from the ports is a complete command frame arriving while programming is still running. In that state the start bit must be ignored and the status must stay on the output. The bench commits a write, raises the select line again at once, and clocks a full WRITE frame to a second address well inside the programming interval. It checks that the status stays at busy throughout. Later reads show that the first word was written and the second address was not touched. The random phase mixes reads, writes, enable and disable commands and guard levels, so that guarded, unlatched and accepted writes appear in many orders.

// File: rtl/sep_pkg.sv
package sep_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    FS_IDLE, FS_OPC, FS_ADDR, FS_WDATA, FS_RDOUT, FS_HOLD
  } fs_t;

  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] OP_EXT  = 2'b00;
  localparam logic [1:0] EXT_EN  = 2'b11;
  localparam logic [1:0] EXT_DIS = 2'b00;

  // lower half is guarded only on the 128-word variant
  function automatic logic in_guarded(input logic [7:0] a, input int aw,
                                      input logic allow);
    return (aw == 7) && !allow && (a < 8'd64);
  endfunction
endpackage

// File: rtl/sep_store.sv
module sep_store #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [15:0]       wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [15:0]       rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sep_prog_timer.sv
module sep_prog_timer #(
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(PROG_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/sep_frame.sv
module sep_frame
  import sep_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sk_rise,
  input  logic              sdin,
  input  logic              busy,
  input  logic              low_wr_allow,
  input  logic [15:0]       rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [15:0]       wr_data,
  output logic              armed,
  output logic              wel,
  output logic              rd_active,
  output logic              rd_bit,
  output logic              start_seen,
  output logic              ewen_hit,
  output logic              ewds_hit
);
  localparam logic [4:0] ADDR_END = 5'(ADDR_W - 1);
  localparam logic [4:0] DATA_END = 5'(DATA_W - 1);
  localparam logic [4:0] RD_END   = 5'(DATA_W);

  fs_t               state;
  logic [4:0]        bitcnt;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       wsh;
  logic [15:0]       rsh;

  logic              step;
  logic              addr_last;
  logic              data_last;
  logic [ADDR_W-1:0] addr_next;
  logic [1:0]        ext_top;

  assign step       = sel && sk_rise && !busy;
  assign addr_next  = {addr[ADDR_W-2:0], sdin};
  assign ext_top    = addr_next[ADDR_W-1 -: 2];
  assign addr_last  = step && (state == FS_ADDR) && (bitcnt == ADDR_END);
  assign data_last  = step && (state == FS_WDATA) && (bitcnt == DATA_END);
  assign start_seen = step && (state == FS_IDLE) && sdin;
  assign ewen_hit   = addr_last && (opc == OP_EXT) && (ext_top == EXT_EN);
  assign ewds_hit   = addr_last && (opc == OP_EXT) && (ext_top == EXT_DIS);

  assign rd_addr   = addr_next;
  assign cur_addr  = addr;
  assign wr_data   = wsh;
  assign rd_active = (state == FS_RDOUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= FS_IDLE;
      bitcnt <= '0;
      opc    <= '0;
      addr   <= '0;
      wsh    <= '0;
      rsh    <= '0;
      rd_bit <= 1'b0;
      armed  <= 1'b0;
    end else if (!sel) begin
      state <= FS_IDLE;
      armed <= 1'b0;
    end else if (step) begin
      case (state)
        FS_IDLE: begin
          if (sdin) begin
            state  <= FS_OPC;
            bitcnt <= '0;
          end
        end
        FS_OPC: begin
          opc <= {opc[0], sdin};
          if (bitcnt == 5'd1) begin
            state  <= FS_ADDR;
            bitcnt <= '0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        FS_ADDR: begin
          addr <= addr_next;
          if (bitcnt == ADDR_END) begin
            bitcnt <= '0;
            case (opc)
              OP_RD: begin
                state  <= FS_RDOUT;
                rsh    <= rd_word;
                rd_bit <= 1'b0;
              end
              OP_WR:   state <= FS_WDATA;
              default: state <= FS_HOLD;
            endcase
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        FS_WDATA: begin
          wsh <= {wsh[14:0], sdin};
          if (data_last) begin
            armed <= wel && !in_guarded(8'(addr), ADDR_W, low_wr_allow);
            state <= FS_HOLD;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        FS_RDOUT: begin
          if (bitcnt == RD_END) begin
            state <= FS_HOLD;
          end else begin
            rd_bit <= rsh[15];
            rsh    <= {rsh[14:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        wel <= 1'b0;
    else if (ewen_hit) wel <= 1'b1;
    else if (ewds_hit) wel <= 1'b0;
  end
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import sep_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdin,
  input  logic low_wr_allow,
  output logic sdout,
  output logic sdout_en
);
  logic              sk_q, sel_q;
  logic              sk_rise, sel_fall;
  logic              prog_start, prog_done, busy;
  logic              armed, wel, rd_active, rd_bit;
  logic              start_seen, ewen_hit, ewds_hit;
  logic              status_mode;
  logic              guard_hit;
  logic [ADDR_W-1:0] rd_addr, cur_addr;
  logic [15:0]       rd_word, wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sk_q  <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      sk_q  <= sclk;
      sel_q <= sel;
    end
  end

  assign sk_rise    = sclk && !sk_q;
  assign sel_fall   = sel_q && !sel;
  assign prog_start = sel_fall && armed;
  assign guard_hit  = in_guarded(8'(cur_addr), ADDR_W, low_wr_allow);

  sep_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sk_rise(sk_rise), .sdin(sdin),
    .busy(busy), .low_wr_allow(low_wr_allow), .rd_word(rd_word),
    .rd_addr(rd_addr), .cur_addr(cur_addr), .wr_data(wr_data),
    .armed(armed), .wel(wel), .rd_active(rd_active), .rd_bit(rd_bit),
    .start_seen(start_seen), .ewen_hit(ewen_hit), .ewds_hit(ewds_hit)
  );

  sep_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(prog_start), .waddr(cur_addr),
    .wdata(wr_data), .raddr(rd_addr), .rdata(rd_word)
  );

  sep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy),
    .done(prog_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          status_mode <= 1'b0;
    else if (prog_start) status_mode <= 1'b1;
    else if (start_seen) status_mode <= 1'b0;
  end

  assign sdout_en = sel && (status_mode || rd_active);
  assign sdout    = sdout_en && (status_mode ? !busy : rd_bit);
endmodule

// File: rtl/serial_eeprom_slave_chk.sv
module serial_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic prog_start,
  input logic busy,
  input logic wel,
  input logic guard_hit,
  input logic ewds_hit,
  input logic status_mode,
  input logic start_seen
);
  // R4
  write_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wel);

  // R6
  guarded_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !guard_hit);

  // R7
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> busy);

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_start);

  // R10
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_seen);

  // R5
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ewds_hit |=> !wel);

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mode && !start_seen && !prog_start) |=> status_mode);
endmodule

bind serial_eeprom_slave serial_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .busy(busy),
  .wel(wel), .guard_hit(guard_hit), .ewds_hit(ewds_hit),
  .status_mode(status_mode), .start_seen(start_seen)
);

// File: tb/serial_eeprom_slave_test.sv
module serial_eeprom_slave_test;
  localparam int PROG = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, sdin = 1'b0, low_wr_allow = 1'b0;
  logic sdout, sdout_en;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_mem [128];
  logic        m_wel;

  always #2 clk = ~clk;

  serial_eeprom_slave uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdin(sdin),
    .low_wr_allow(low_wr_allow), .sdout(sdout), .sdout_en(sdout_en)
  );

  function automatic bit exp_guard(input logic [6:0] a, input logic allow);
    return (a < 7'd64) && !allow;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_in(input logic b);
    @(negedge clk); sdin = b; sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic sel_up;
    @(negedge clk); sel = 1'b1;
    @(negedge clk);
  endtask

  task automatic sel_down;
    @(negedge clk); sel = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [6:0] a, input int zeros);
    for (int i = 0; i < zeros; i++) bit_in(1'b0);
    bit_in(1'b1);
    bit_in(op[1]); bit_in(op[0]);
    for (int i = 6; i >= 0; i--) bit_in(a[i]);
  endtask

  task automatic do_read(input logic [6:0] a, input int zeros, input string req);
    logic [15:0] w;
    bit en_ok;
    sel_up;
    send_hdr(2'b10, a, zeros);
    chk(sdout_en && !sdout, "R3 dummy bit", {sdout_en, sdout}, 2);
    en_ok = 1;
    for (int i = 15; i >= 0; i--) begin
      bit_in(1'b0);
      w[i] = sdout;
      if (!sdout_en) en_ok = 0;
    end
    chk(en_ok, "R3 enable during data", 0, 1);
    chk(w == m_mem[a], req, w, m_mem[a]);
    bit_in(1'b0);
    chk(!sdout_en, "R3 release after bit 0", sdout_en, 0);
    sel_down;
    chk(!sdout_en, "R9 select low", sdout_en, 0);
  endtask

  task automatic do_ext(input logic [1:0] code);
    sel_up;
    send_hdr(2'b00, {code, 5'b10101}, 0);
    sel_down;
    if (code == 2'b11) m_wel = 1'b1;
    else if (code == 2'b00) m_wel = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d, input logic allow);
    bit eff;
    low_wr_allow = allow;
    sel_up;
    send_hdr(2'b01, a, 1);
    chk(!sdout_en, "R9 floating during entry", sdout_en, 0);
    for (int i = 15; i >= 0; i--) bit_in(d[i]);
    sel_down;
    eff = m_wel && !exp_guard(a, allow);
    sel_up;
    if (eff) begin
      chk(sdout_en && !sdout, "R8 busy", {sdout_en, sdout}, 2);
      repeat (PROG + 4) @(negedge clk);
      chk(sdout_en && sdout, "R8 ready", {sdout_en, sdout}, 3);
      m_mem[a] = d;
    end else begin
      chk(!sdout_en, "R4 R6 no programming", sdout_en, 0);
    end
    sel_down;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) m_mem[i] = '0;
    m_wel = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sdout_en, "R9 reset state", sdout_en, 0);

    // R4: latch clear after reset, write dropped
    do_write(7'd70, 16'hBEEF, 1'b1);
    do_read(7'd70, 0, "R4 write ignored without latch");

    // R1/R2: enable, write both ends, read with leading zeros
    do_ext(2'b11);
    do_write(7'd127, 16'h8001, 1'b1);
    do_write(7'd0, 16'h7FFE, 1'b1);
    do_read(7'd127, 3, "R2 leading zeros read");
    do_read(7'd0, 0, "R1 lowest word");

    // R6: guard blocks lower half only
    do_write(7'd5, 16'h1111, 1'b0);
    do_read(7'd5, 0, "R6 guarded write dropped");
    do_write(7'd64, 16'h2222, 1'b0);
    do_read(7'd64, 0, "R6 upper half writable");
    do_write(7'd63, 16'h3333, 1'b1);
    do_read(7'd63, 0, "R6 guard released");

    // R7: truncated write frame
    sel_up;
    send_hdr(2'b01, 7'd80, 0);
    for (int i = 0; i < 8; i++) bit_in(1'b1);
    sel_down;
    sel_up;
    chk(!sdout_en, "R7 truncated frame no status", sdout_en, 0);
    sel_down;
    do_read(7'd80, 0, "R7 truncated frame no write");

    // R10: frame sent while busy is ignored, status held
    low_wr_allow = 1'b1;
    sel_up;
    send_hdr(2'b01, 7'd100, 0);
    for (int i = 15; i >= 0; i--) bit_in(i[0]);
    sel_down;
    m_mem[100] = 16'hAAAA;
    sel_up;
    send_hdr(2'b01, 7'd101, 0);
    for (int i = 15; i >= 0; i--) bit_in(1'b1);
    chk(sdout_en && !sdout, "R10 busy status held", {sdout_en, sdout}, 2);
    sel_down;
    sel_up;
    repeat (PROG + 4) @(negedge clk);
    chk(sdout_en && sdout, "R10 ready held", {sdout_en, sdout}, 3);
    bit_in(1'b0);
    chk(sdout_en && sdout, "R10 zero keeps status", {sdout_en, sdout}, 3);
    bit_in(1'b1);
    chk(!sdout_en, "R10 start bit clears status", sdout_en, 0);
    sel_down;
    do_read(7'd100, 0, "R10 first write landed");
    do_read(7'd101, 0, "R10 busy write ignored");

    // R2/R5: reserved code leaves latch, disable clears it
    do_ext(2'b01);
    do_write(7'd90, 16'h4444, 1'b1);
    do_read(7'd90, 0, "R2 reserved ext code no effect");
    do_ext(2'b00);
    do_write(7'd91, 16'h5555, 1'b1);
    do_read(7'd91, 0, "R5 disable blocks write");
    do_read(7'd127, 0, "R5 read with latch clear");

    // random mix
    for (int n = 0; n < 40; n++) begin
      int op;
      logic [6:0] a;
      op = int'($urandom % 5);
      a  = 7'($urandom);
      case (op)
        0: do_ext(2'b11);
        1: do_ext(2'b00);
        2, 3: do_write(a, 16'($urandom), 1'($urandom));
        default: do_read(a, int'($urandom % 3), "R1 random read");
      endcase
    end
    for (int i = 0; i < 8; i++) do_read(7'(i * 17), 0, "R1 final sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule